// File: doc/BRIEF.md
# Critical-Path Clock Tuning Sequencer

This block finds, at run time, the fastest full-speed oscillator setting at which the core's ALU still adds correctly. A mode controller sends a start pulse. The sequencer then takes over the core's datapath. The instruction register receives the all-zero NOP instead of the fetched word. The program counter is told to hold its value. The ALU inputs are switched from their normal sources to fixed test operands. The oscillator setting is then driven with candidate codes, starting at the slowest full-speed code.

Each candidate takes two processor cycles of four oscillator clocks each. The first is a settling cycle with both operands zero, which leaves the carry chain in a known state. The second is a trial cycle that adds all-ones and one. This drives a carry through every bit. In the last clock of the trial, the sum and carry-out are checked. A pass moves the search to the next faster code. A failure, or a pass at the top code, ends the search. The block then reports the last passing code on the oscillator-code output and pulses done. If even the slowest candidate fails, that code is still reported and an error flag is raised.

Top module: `tune_seq`

## Requirements
- R1: After reset the block is idle: busy, done, error, force-NOP, PC-hold and operand-select are low, and the oscillator code is 8.
- R2: From the clock after a start pulse sampled while idle until tuning ends, busy, force-NOP, PC-hold and operand-select are high, and the instruction output is all zeros. While idle, the instruction output equals the fetched instruction.
- R3: While idle, the ALU operand outputs equal the normal operand inputs.
- R4: Each candidate takes 4 clocks with both ALU operands 8'h00, then 4 clocks with operand A 8'hFF and operand B 8'h01. The candidate code is on the oscillator-code output for all 8 clocks.
- R5: A trial passes only if, in its fourth clock, the ALU sum is 8'h00 and the carry-out is 1.
- R6: The search starts at code 8 and steps up by one after each passing trial. It ends at the first failing trial or after code 15 passes.
- R7: While idle after tuning, the oscillator-code output holds the last passing code, or 15 if every candidate passed.
- R8: If code 8 fails, the result is 8 and the error output is high while idle. A new start clears the error.
- R9: Done is high for exactly one clock, the clock in which busy has just fallen.
- R10: A start pulse while tuning is in progress has no effect on the sequence.
- R11: The oscillator-code output always lies between 8 and 15 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tune_start | input | 1 | Start request from the mode controller |
| tune_busy | output | 1 | Tuning in progress |
| tune_done | output | 1 | One-clock pulse when tuning ends |
| tune_err | output | 1 | Slowest candidate failed |
| osc_code | output | 4 | Oscillator frequency code: candidate while busy, result while idle |
| force_nop | output | 1 | Instruction register is loaded with NOP |
| pc_hold | output | 1 | Program counter must hold its value |
| opsel_test | output | 1 | ALU operands come from the test pattern |
| ir_fetch | input | 12 | Fetched instruction word |
| ir_out | output | 12 | Word to be loaded into the instruction register |
| norm_opa | input | 8 | Normal ALU operand A |
| norm_opb | input | 8 | Normal ALU operand B |
| alu_opa | output | 8 | Operand A driven to the ALU |
| alu_opb | output | 8 | Operand B driven to the ALU |
| alu_sum | input | 8 | ALU sum result |
| alu_cout | input | 1 | ALU carry-out |

## Verification
The assertions assume the ALU result inputs depend only on the operands this block drives and on the code it selects. They also assume start is a clean synchronous level. The bench ALU meets these assumptions. It is an adder whose sum arrives at once at codes up to a chosen limit. Above that limit the sum lags by four clocks, so a trial at a too-fast code reads the settling-cycle result. The bench also keeps normal operands and fetched words changing every clock, so any pass-through or override error shows up.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_TRIAL  = 2'd2
  } tune_st_e;
endpackage

// File: rtl/tune_phase_ctr.sv
module tune_phase_ctr #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!run) begin
      phase_q <= '0;
    end else if (phase_q == LAST_PH) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign last = run && (phase_q == LAST_PH);
endmodule

// File: rtl/tune_fsm.sv
module tune_fsm
  import tune_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int CODE_LO = 8,
  parameter int CODE_HI = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phase_last,
  input  logic              pass,
  output tune_st_e          state,
  output logic [CODE_W-1:0] cand,
  output logic [CODE_W-1:0] result,
  output logic              err,
  output logic              done
);
  localparam logic [CODE_W-1:0] LO = CODE_W'(CODE_LO);
  localparam logic [CODE_W-1:0] HI = CODE_W'(CODE_HI);

  function automatic logic [CODE_W-1:0] fallback(input logic [CODE_W-1:0] c);
    return (c == LO) ? LO : c - 1'b1;
  endfunction

  tune_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cand   <= LO;
      result <= LO;
      err    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_SETTLE;
            cand <= LO;
            err  <= 1'b0;
          end
        end
        ST_SETTLE: begin
          if (phase_last) st_q <= ST_TRIAL;
        end
        ST_TRIAL: begin
          if (phase_last) begin
            if (pass && cand != HI) begin
              cand <= cand + 1'b1;
              st_q <= ST_SETTLE;
            end else begin
              st_q   <= ST_IDLE;
              done   <= 1'b1;
              result <= pass ? cand : fallback(cand);
              err    <= !pass && (cand == LO);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state = st_q;
endmodule

// File: rtl/tune_oper_mux.sv
module tune_oper_mux #(
  parameter int DATA_W = 8,
  parameter int IR_W   = 12
) (
  input  logic              busy,
  input  logic              trial,
  input  logic [IR_W-1:0]   ir_fetch,
  input  logic [DATA_W-1:0] norm_opa,
  input  logic [DATA_W-1:0] norm_opb,
  output logic [IR_W-1:0]   ir_out,
  output logic [DATA_W-1:0] alu_opa,
  output logic [DATA_W-1:0] alu_opb
);
  localparam logic [IR_W-1:0] NOP_WORD = '0;

  function automatic logic [DATA_W-1:0] pat_a(input logic t);
    return t ? {DATA_W{1'b1}} : '0;
  endfunction

  function automatic logic [DATA_W-1:0] pat_b(input logic t);
    return t ? DATA_W'(1) : '0;
  endfunction

  for (genvar i = 0; i < DATA_W; i++) begin : g_opbit
    assign alu_opa[i] = busy ? pat_a(trial)[i] : norm_opa[i];
    assign alu_opb[i] = busy ? pat_b(trial)[i] : norm_opb[i];
  end

  assign ir_out = busy ? NOP_WORD : ir_fetch;
endmodule

// File: rtl/tune_seq.sv
module tune_seq
  import tune_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int IR_W    = 12,
  parameter int CODE_W  = 4,
  parameter int CODE_LO = 8,
  parameter int CODE_HI = 15,
  parameter int PHASES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tune_start,
  output logic              tune_busy,
  output logic              tune_done,
  output logic              tune_err,
  output logic [CODE_W-1:0] osc_code,
  output logic              force_nop,
  output logic              pc_hold,
  output logic              opsel_test,
  input  logic [IR_W-1:0]   ir_fetch,
  output logic [IR_W-1:0]   ir_out,
  input  logic [DATA_W-1:0] norm_opa,
  input  logic [DATA_W-1:0] norm_opb,
  output logic [DATA_W-1:0] alu_opa,
  output logic [DATA_W-1:0] alu_opb,
  input  logic [DATA_W-1:0] alu_sum,
  input  logic              alu_cout
);
  function automatic logic sum_ok(input logic [DATA_W-1:0] s, input logic c);
    return (s == '0) && c;
  endfunction

  tune_st_e          state;
  logic [CODE_W-1:0] cand, result;
  logic              phase_last;
  logic              trial_step;
  logic              trial_eval;
  logic              trial_pass;

  assign tune_busy  = (state != ST_IDLE);
  assign trial_step = (state == ST_TRIAL);
  assign trial_eval = trial_step && phase_last;
  assign trial_pass = sum_ok(alu_sum, alu_cout);

  tune_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (tune_busy),
    .last  (phase_last)
  );

  tune_fsm #(.CODE_W(CODE_W), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (tune_start),
    .phase_last (phase_last),
    .pass       (trial_pass),
    .state      (state),
    .cand       (cand),
    .result     (result),
    .err        (tune_err),
    .done       (tune_done)
  );

  tune_oper_mux #(.DATA_W(DATA_W), .IR_W(IR_W)) u_mux (
    .busy     (tune_busy),
    .trial    (trial_step),
    .ir_fetch (ir_fetch),
    .norm_opa (norm_opa),
    .norm_opb (norm_opb),
    .ir_out   (ir_out),
    .alu_opa  (alu_opa),
    .alu_opb  (alu_opb)
  );

  assign osc_code   = tune_busy ? cand : result;
  assign force_nop  = tune_busy;
  assign pc_hold    = tune_busy;
  assign opsel_test = tune_busy;
endmodule

// File: rtl/tune_seq_chk.sv
module tune_seq_chk #(
  parameter int DATA_W  = 8,
  parameter int IR_W    = 12,
  parameter int CODE_W  = 4,
  parameter int CODE_LO = 8,
  parameter int CODE_HI = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tune_busy,
  input logic              tune_done,
  input logic              tune_err,
  input logic [CODE_W-1:0] osc_code,
  input logic              force_nop,
  input logic              pc_hold,
  input logic [IR_W-1:0]   ir_fetch,
  input logic [IR_W-1:0]   ir_out,
  input logic [DATA_W-1:0] norm_opa,
  input logic [DATA_W-1:0] norm_opb,
  input logic [DATA_W-1:0] alu_opa,
  input logic [DATA_W-1:0] alu_opb,
  input logic              trial_step,
  input logic              trial_eval,
  input logic              trial_pass
);
  a_r2_nop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tune_busy |-> (ir_out == '0 && force_nop && pc_hold));

  a_r3_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !tune_busy |-> (alu_opa == norm_opa && alu_opb == norm_opb && ir_out == ir_fetch));

  a_r4_trial_ops: assert property (@(posedge clk) disable iff (!rst_n)
    trial_step |-> (alu_opa == {DATA_W{1'b1}} && alu_opb == DATA_W'(1)));

  a_r4_settle_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_busy && !trial_step) |-> (alu_opa == '0 && alu_opb == '0));

  a_r5_fail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_eval && !trial_pass) |=> !tune_busy);

  a_r6_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_busy && $past(tune_busy) && osc_code != $past(osc_code))
      |-> osc_code == CODE_W'($past(osc_code) + 1'b1));

  a_r8_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    tune_err |-> (osc_code == CODE_W'(CODE_LO) && !tune_busy));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tune_done |=> !tune_done);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tune_done |-> (!tune_busy && $past(tune_busy)));

  a_r10_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (tune_busy && !trial_eval) |=> tune_busy);

  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_code >= CODE_W'(CODE_LO) && osc_code <= CODE_W'(CODE_HI)));
endmodule

bind tune_seq tune_seq_chk #(
  .DATA_W(DATA_W), .IR_W(IR_W), .CODE_W(CODE_W),
  .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tune_busy  (tune_busy),
  .tune_done  (tune_done),
  .tune_err   (tune_err),
  .osc_code   (osc_code),
  .force_nop  (force_nop),
  .pc_hold    (pc_hold),
  .ir_fetch   (ir_fetch),
  .ir_out     (ir_out),
  .norm_opa   (norm_opa),
  .norm_opb   (norm_opb),
  .alu_opa    (alu_opa),
  .alu_opb    (alu_opb),
  .trial_step (trial_step),
  .trial_eval (trial_eval),
  .trial_pass (trial_pass)
);

// File: tb/tune_seq_tb_top.sv
module tune_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tune_start = 1'b0;
  logic        tune_busy, tune_done, tune_err;
  logic [3:0]  osc_code;
  logic        force_nop, pc_hold, opsel_test;
  logic [11:0] ir_fetch = 12'h000;
  logic [11:0] ir_out;
  logic [7:0]  norm_opa = 8'h00, norm_opb = 8'h00;
  logic [7:0]  alu_opa, alu_opb;
  logic [7:0]  alu_sum;
  logic        alu_cout;

  always #2.5 clk = ~clk;

  tune_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tune_start(tune_start),
    .tune_busy(tune_busy), .tune_done(tune_done), .tune_err(tune_err),
    .osc_code(osc_code), .force_nop(force_nop), .pc_hold(pc_hold),
    .opsel_test(opsel_test), .ir_fetch(ir_fetch), .ir_out(ir_out),
    .norm_opa(norm_opa), .norm_opb(norm_opb), .alu_opa(alu_opa),
    .alu_opb(alu_opb), .alu_sum(alu_sum), .alu_cout(alu_cout)
  );

  // Bench ALU: instant sum at codes up to lim, otherwise four clocks late.
  int       lim = 15;
  logic [8:0] lag [4];
  logic [8:0] fast_res;
  always_comb fast_res = {1'b0, alu_opa} + {1'b0, alu_opb};
  always @(posedge clk) begin
    lag[3] <= lag[2];
    lag[2] <= lag[1];
    lag[1] <= lag[0];
    lag[0] <= fast_res;
  end
  initial for (int i = 0; i < 4; i++) lag[i] = 9'h0;
  assign {alu_cout, alu_sum} = (int'(osc_code) <= lim) ? fast_res : lag[3];

  // Reference model: expected per-clock trace held in a queue.
  typedef struct {bit busy; bit done; bit err; bit trial; int code;} rec_t;
  rec_t q[$];
  int   last_code = 8;
  bit   last_err = 1'b0;
  int   n_run = 0, n_fail = 0;
  bit   checking = 1'b0, finished = 1'b0;
  string ctx = "";

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s%s actual=%0h expected=%0h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic plan(input int l);
    rec_t r;
    int c;
    q.push_back('{busy:0, done:0, err:last_err, trial:0, code:last_code});
    c = 8;
    forever begin
      for (int k = 0; k < 8; k++)
        q.push_back('{busy:1, done:0, err:0, trial:(k >= 4), code:c});
      if (c <= l) begin
        if (c == 15) begin r = '{busy:0, done:1, err:0, trial:0, code:15}; break; end
        c++;
      end else begin
        r = '{busy:0, done:1, err:(c == 8), trial:0, code:(c == 8) ? 8 : c - 1};
        break;
      end
    end
    q.push_back(r);
  endtask

  always @(negedge clk) begin
    if (checking) begin
      rec_t e;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (!e.busy) begin last_code = e.code; last_err = e.err; end
      end else begin
        e = '{busy:0, done:0, err:last_err, trial:0, code:last_code};
      end
      chk(tune_busy === e.busy, "R2 busy", tune_busy, e.busy);
      chk(force_nop === e.busy && pc_hold === e.busy && opsel_test === e.busy,
          "R2 controls", {force_nop, pc_hold, opsel_test}, {3{e.busy}});
      chk(ir_out === (e.busy ? 12'h000 : ir_fetch), "R2 ir", ir_out, e.busy ? 0 : ir_fetch);
      if (e.busy) begin
        chk(alu_opa === (e.trial ? 8'hFF : 8'h00) && alu_opb === (e.trial ? 8'h01 : 8'h00),
            "R4 ops", {alu_opa, alu_opb}, e.trial ? 16'hFF01 : 16'h0000);
        chk(int'(osc_code) == e.code, "R5 R6 code", osc_code, e.code);
      end else begin
        chk(alu_opa === norm_opa && alu_opb === norm_opb, "R3 ops",
            {alu_opa, alu_opb}, {norm_opa, norm_opb});
        chk(int'(osc_code) == e.code, "R7 result", osc_code, e.code);
      end
      chk(tune_done === e.done, "R9 done", tune_done, e.done);
      chk(tune_err === e.err, "R8 err", tune_err, e.err);
      chk(osc_code >= 4'd8, "R11 range", osc_code, 8);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    ir_fetch = 12'($urandom);
    norm_opa = 8'($urandom);
    norm_opb = 8'($urandom);
  endtask

  task automatic run_tune(input int l, input string tag);
    ctx = tag;
    lim = l;
    plan(l);
    tune_start = 1'b1;
    tick();
    tune_start = 1'b0;
    while (q.size() > 0) tick();
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk(tune_busy === 1'b0 && tune_done === 1'b0 && tune_err === 1'b0, "R1 flags",
        {tune_busy, tune_done, tune_err}, 0);
    chk(force_nop === 1'b0 && pc_hold === 1'b0 && opsel_test === 1'b0, "R1 controls",
        {force_nop, pc_hold, opsel_test}, 0);
    chk(osc_code === 4'd8, "R1 code", osc_code, 8);
    tick();
    checking = 1'b1;
    repeat (4) tick();
    run_tune(11, " lim11");
    run_tune(20, " all-pass");
    run_tune(5, " code8-fail");
    run_tune(8, " only8");
    // R10: extra start pulses during tuning must leave the trace unchanged.
    ctx = " R10 restart";
    lim = 13;
    plan(13);
    tune_start = 1'b1;
    tick();
    tune_start = 1'b0;
    repeat (6) tick();
    tune_start = 1'b1;
    tick();
    tune_start = 1'b0;
    repeat (11) tick();
    tune_start = 1'b1;
    tick();
    tune_start = 1'b0;
    while (q.size() > 0) tick();
    repeat (3) tick();
    run_tune(5, " err-again");
    run_tune(14, " lim14");
    checking = 1'b0;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule